// File: doc/BRIEF.md
# Elementary Cellular Automaton Row Engine

This block runs a one-dimensional, two-state cellular automaton over a row of `WIDTH` cells. Every cell's next state is looked up in an 8-bit rule number, addressed by the three-bit pattern formed by the left neighbour, the cell itself and the right neighbour. The whole row advances in a single clock cycle, so each enabled cycle produces one new generation. The output stream of rows forms a space-time picture that is `WIDTH` pixels wide and `GENS` rows tall.

A seed row is captured with a load strobe and emitted at once as generation 0. A start pulse captures the rule number and launches the run. After that, one row is produced per cycle in which `enable` is high, until generation `GENS-1` has been emitted and `done` is raised. Cells at the two ends see a constant 0 beyond the row, unless the `WRAP` parameter joins the ends into a ring.

Top module: `eca_row_engine`

## Requirements
- R1: A cell's next state is bit `{left, self, right}` of the latched rule, with that pattern read as an unsigned 3-bit index. Pattern 000 selects bit 0 and pattern 111 selects bit 7. Cell `WIDTH-1` is the leftmost cell, so the left neighbour of cell i is cell i+1.
- R2: Each step computes every cell of the new row from the previous row only, so exactly one generation is produced per enabled step.
- R3: With `WRAP`=0, a missing neighbour at either end reads as 0. With `WRAP`=1, cell 0 and cell `WIDTH-1` are each other's neighbours.
- R4: When `seed_load` is high at a clock edge, `row_out` takes `seed_in` after that edge, `gen_count` goes to 0, `done` clears and `row_valid` pulses for that cycle.
- R5: `row_valid` is high for exactly one cycle per generation. Every pulse that is not a seed capture comes with `gen_count` one higher than before, and `gen_count` never exceeds `GENS-1`.
- R6: `done` rises in the same cycle as the row of generation `GENS-1`. While it stays high, no further rows are produced and `row_out` holds its value until a load or a start.
- R7: The rule is captured from `rule_in` only when a run is launched. Changes on `rule_in`, and start pulses that arrive during a run, have no effect on the rows produced.
- R8: While `enable` is low, no generation is produced: `row_valid` stays low and `row_out` and `gen_count` hold their values.
- R9: When load and start coincide in one cycle, the seed is emitted as generation 0 under the rule captured in that cycle, and generation 1 follows on the next enabled edge.
- R10: A load without start during a run aborts the run. The seed becomes generation 0 with `done` low, and no further rows appear until the next start.
- R11: After reset, `row_out`, `gen_count`, `row_valid` and `done` are all 0.
- R12: A start while idle without a load treats the current row as generation 0 without a pulse. Generations 1 to `GENS-1` then follow from that row under the newly captured rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rule_in | input | 8 | Rule number, captured at launch |
| seed_in | input | WIDTH | Seed row pattern |
| seed_load | input | 1 | Capture the seed row and emit it as generation 0 |
| start | input | 1 | Launch a run when idle |
| enable | input | 1 | Allow a generation step this cycle |
| row_out | output | WIDTH | Current row, bit WIDTH-1 leftmost |
| row_valid | output | 1 | One-cycle pulse per emitted row |
| gen_count | output | $clog2(GENS) | Generation number of row_out |
| done | output | 1 | Final generation has been emitted |

## Verification
Two functions can fall in the same cycle here. A seed load can meet a start pulse, and a seed load can also land on a cycle where a running engine would otherwise step. The bench provokes the first by raising both strobes on one edge and expects the seed as generation 0, then generation 1 under the new rule on the next edge. It provokes the second by loading two generations into a run and expects only the new seed, with the count reset and no further rows. A scoreboard matches every emitted row, count and done flag against an independent row model, for both boundary variants at once.

// File: rtl/eca_pkg.sv
package eca_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_t;

  // Rule lookup: the neighbourhood {left, self, right} addresses the rule bits.
  function automatic logic rule_bit(input logic [7:0] rule,
                                    input logic lft, input logic ctr, input logic rgt);
    return rule[{lft, ctr, rgt}];
  endfunction

endpackage

// File: rtl/eca_next_row.sv
module eca_next_row #(
  parameter int WIDTH = 640,
  parameter bit WRAP  = 1'b0
) (
  input  logic [7:0]       rule,
  input  logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] nxt
);
  import eca_pkg::*;

  logic edge_left;   // neighbour seen left of the leftmost cell
  logic edge_right;  // neighbour seen right of the rightmost cell

  generate
    if (WRAP) begin : g_ring
      assign edge_left  = cur[0];
      assign edge_right = cur[WIDTH-1];
    end else begin : g_null
      assign edge_left  = 1'b0;
      assign edge_right = 1'b0;
    end
  endgenerate

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
      logic lft;
      logic rgt;
      if (i == WIDTH-1) begin : g_l_edge
        assign lft = edge_left;
      end else begin : g_l_in
        assign lft = cur[i+1];
      end
      if (i == 0) begin : g_r_edge
        assign rgt = edge_right;
      end else begin : g_r_in
        assign rgt = cur[i-1];
      end
      assign nxt[i] = rule_bit(rule, lft, cur[i], rgt);
    end
  endgenerate

endmodule

// File: rtl/eca_gen_counter.sv
module eca_gen_counter #(
  parameter int GENS = 480,
  parameter int CW   = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          step,
  output logic [CW-1:0] count,
  output logic          final_step
);
  localparam logic [CW-1:0] LAST_M1 = CW'(GENS - 2);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      count <= '0;
    end else if (step) begin
      count <= count + 1'b1;
    end
  end

  // The step taken from this count produces the final generation.
  assign final_step = (count == LAST_M1);

endmodule

// File: rtl/eca_row_engine.sv
module eca_row_engine #(
  parameter int WIDTH = 640,
  parameter int GENS  = 480,
  parameter bit WRAP  = 1'b0,
  localparam int CW   = $clog2(GENS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       rule_in,
  input  logic [WIDTH-1:0] seed_in,
  input  logic             seed_load,
  input  logic             start,
  input  logic             enable,
  output logic [WIDTH-1:0] row_out,
  output logic             row_valid,
  output logic [CW-1:0]    gen_count,
  output logic             done
);
  import eca_pkg::*;

  run_state_t       state_q;
  logic [7:0]       rule_q;
  logic [WIDTH-1:0] next_row;
  logic             launch;
  logic             step;
  logic             final_step;

  assign launch = start && (seed_load || state_q == ST_IDLE);
  assign step   = (state_q == ST_RUN) && enable && !seed_load;

  eca_next_row #(.WIDTH(WIDTH), .WRAP(WRAP)) u_next (
    .rule (rule_q),
    .cur  (row_out),
    .nxt  (next_row)
  );

  eca_gen_counter #(.GENS(GENS), .CW(CW)) u_count (
    .clk        (clk),
    .rst        (rst),
    .clear      (seed_load || launch),
    .step       (step),
    .count      (gen_count),
    .final_step (final_step)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      rule_q    <= '0;
      row_out   <= '0;
      row_valid <= 1'b0;
      done      <= 1'b0;
    end else begin
      row_valid <= 1'b0;
      if (launch) begin
        rule_q <= rule_in;
      end
      if (seed_load) begin
        row_out   <= seed_in;
        row_valid <= 1'b1;
        done      <= 1'b0;
        state_q   <= launch ? ST_RUN : ST_IDLE;
      end else if (launch) begin
        done    <= 1'b0;
        state_q <= ST_RUN;
      end else if (step) begin
        row_out   <= next_row;
        row_valid <= 1'b1;
        if (final_step) begin
          done    <= 1'b1;
          state_q <= ST_IDLE;
        end
      end
    end
  end

endmodule

// File: rtl/eca_row_engine_chk.sv
module eca_row_engine_chk #(
  parameter int WIDTH = 640,
  parameter int GENS  = 480,
  parameter int CW    = 9
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] seed_in,
  input logic             seed_load,
  input logic             start,
  input logic             enable,
  input logic [WIDTH-1:0] row_out,
  input logic             row_valid,
  input logic [CW-1:0]    gen_count,
  input logic             done
);

  assert_seed_capture_R4: assert property (@(posedge clk) disable iff (rst)
    seed_load |=> row_valid && gen_count == '0 && !done && row_out == $past(seed_in));

  assert_count_step_R5: assert property (@(posedge clk) disable iff (rst)
    !seed_load |=> (!row_valid || gen_count == CW'($past(gen_count) + 1'b1)));

  always @(posedge clk) begin
    if (!rst) begin
      assert_count_range_R5: assert (int'(gen_count) < GENS);
    end
  end

  assert_done_final_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> row_valid && gen_count == CW'(GENS - 1));

  assert_done_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (done && !seed_load && !start) |=> done && !row_valid && $stable(row_out));

  assert_pause_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!enable && !seed_load) |=> !row_valid && $stable(row_out) && $stable(gen_count));

  assert_abort_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (seed_load && !start) ##1 !seed_load |=> !row_valid);

endmodule

bind eca_row_engine eca_row_engine_chk #(.WIDTH(WIDTH), .GENS(GENS), .CW(CW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .seed_in   (seed_in),
  .seed_load (seed_load),
  .start     (start),
  .enable    (enable),
  .row_out   (row_out),
  .row_valid (row_valid),
  .gen_count (gen_count),
  .done      (done)
);

// File: tb/sim_eca_row_engine.sv
module sim_eca_row_engine;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 16;
  localparam int G  = 6;
  localparam int GW = $clog2(G);

  typedef struct packed {
    logic [W-1:0]  row;
    logic [GW-1:0] gen;
    logic          fin;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0]   rule_in = '0;
  logic [W-1:0] seed_in = '0;
  logic seed_load = 1'b0, start = 1'b0, enable = 1'b1;
  logic [W-1:0]  row0, row1;
  logic          v0, v1, d0, d1;
  logic [GW-1:0] c0, c1;

  item_t q0[$];
  item_t q1[$];
  logic [W-1:0] last0, last1;
  string tag = "R11";
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eca_row_engine #(.WIDTH(W), .GENS(G), .WRAP(1'b0)) u0 (
    .clk(clk), .rst(rst), .rule_in(rule_in), .seed_in(seed_in), .seed_load(seed_load),
    .start(start), .enable(enable), .row_out(row0), .row_valid(v0), .gen_count(c0), .done(d0));

  eca_row_engine #(.WIDTH(W), .GENS(G), .WRAP(1'b1)) u1 (
    .clk(clk), .rst(rst), .rule_in(rule_in), .seed_in(seed_in), .seed_load(seed_load),
    .start(start), .enable(enable), .row_out(row1), .row_valid(v1), .gen_count(c1), .done(d1));

  function automatic logic [W-1:0] model_step(input logic [W-1:0] r, input logic [7:0] rule,
                                               input bit ring);
    logic [W-1:0] n;
    for (int i = 0; i < W; i++) begin
      logic l, rr;
      l  = (i == W-1) ? (ring ? r[0] : 1'b0) : r[(i+1) % W];
      rr = (i == 0) ? (ring ? r[W-1] : 1'b0) : r[(i+W-1) % W];
      n[i] = rule[{l, r[i], rr}];
    end
    return n;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // Push the expected items of generations lo..hi grown from the given base rows.
  task automatic push(input logic [W-1:0] b0, input logic [W-1:0] b1, input logic [7:0] rule,
                      input int lo, input int hi);
    logic [W-1:0] r0, r1;
    r0 = b0; r1 = b1;
    for (int g = 0; g <= hi; g++) begin
      if (g >= lo) begin
        q0.push_back('{row: r0, gen: GW'(g), fin: (g == G-1)});
        q1.push_back('{row: r1, gen: GW'(g), fin: (g == G-1)});
      end
      if (g < hi) begin
        r0 = model_step(r0, rule, 1'b0);
        r1 = model_step(r1, rule, 1'b1);
      end
    end
    last0 = r0; last1 = r1;
  endtask

  task automatic launch(input logic [W-1:0] seed, input logic [7:0] rule, input bit together);
    push(seed, seed, rule, 0, G-1);
    @(negedge clk);
    seed_in = seed; seed_load = 1'b1;
    if (together) begin rule_in = rule; start = 1'b1; end
    @(negedge clk);
    seed_load = 1'b0;
    if (!together) begin
      rule_in = rule; start = 1'b1;
      @(negedge clk);
    end
    start = 1'b0;
    rule_in = ~rule;  // later changes must not matter (R7)
  endtask

  task automatic restart(input logic [7:0] rule);
    push(last0, last1, rule, 1, G-1);
    @(negedge clk);
    rule_in = rule; start = 1'b1;
    @(negedge clk);
    start = 1'b0; rule_in = ~rule;
  endtask

  task automatic settle(input string req);
    logic [W-1:0] h0;
    repeat (G + 2) @(negedge clk);
    chk(q0.size() == 0 && q1.size() == 0, req, "rows outstanding", 64'(q0.size() + q1.size()), 0);
    chk(d0 && d1, "R6", "done after final row", {d0, d1}, 2'b11);
    h0 = row0;
    repeat (3) @(negedge clk);
    chk(row0 == h0, "R6", "row held while done", row0, h0);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (v0) begin
        if (q0.size() == 0) chk(1'b0, tag, "unexpected row u0", row0, 0);
        else begin
          item_t e;
          e = q0.pop_front();
          chk(row0 == e.row && c0 == e.gen && d0 == e.fin, tag, "u0 {row,gen,done}",
              {row0, c0, d0}, {e.row, e.gen, e.fin});
        end
      end
      if (v1) begin
        if (q1.size() == 0) chk(1'b0, tag, "unexpected row u1", row1, 0);
        else begin
          item_t e;
          e = q1.pop_front();
          chk(row1 == e.row && c1 == e.gen && d1 == e.fin, tag, "u1 {row,gen,done}",
              {row1, c1, d1}, {e.row, e.gen, e.fin});
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not end");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(row0 == '0 && c0 == '0 && !v0 && !d0, "R11", "reset state", {row0, c0, v0, d0}, 0);

    // R1: all-zero row under rule 1, pattern 000 selects bit 0
    tag = "R1";
    launch('0, 8'd1, 1'b0);
    settle("R1");
    // R1 R2: single centre cell, rule 90 then rule 110
    tag = "R2";
    launch(16'h0100, 8'd90, 1'b0);
    settle("R2");
    tag = "R1";
    launch(16'h0100, 8'd110, 1'b0);
    settle("R1");
    // R3: edge cells set, rule 30 and rule 124 show boundary handling
    tag = "R3";
    launch(16'h8001, 8'd30, 1'b0);
    settle("R3");
    launch(16'hC003, 8'd124, 1'b0);
    settle("R3");
    // R12: restart from the final row under a new rule
    tag = "R12";
    restart(8'd30);
    settle("R12");
    // R9: load and start in one cycle
    tag = "R9";
    launch(16'h2468, 8'd150, 1'b1);
    settle("R9");
    // R7: start pulse with another rule during the run is ignored
    tag = "R7";
    launch(16'h0810, 8'd110, 1'b0);
    @(negedge clk);
    rule_in = 8'd255; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    settle("R7");
    // R8: pause with enable low
    tag = "R8";
    launch(16'h1234, 8'd30, 1'b0);
    @(negedge clk);
    enable = 1'b0;
    begin
      logic [W-1:0] h;
      logic [GW-1:0] hc;
      h = row0; hc = c0;
      repeat (3) begin
        @(negedge clk);
        chk(row0 == h && c0 == hc, "R8", "state held while paused", {row0, c0}, {h, hc});
      end
    end
    enable = 1'b1;
    settle("R8");
    // R10: load during a run aborts it
    tag = "R10";
    push(16'h00F0, 16'h00F0, 8'd90, 0, 2);
    @(negedge clk);
    seed_in = 16'h00F0; seed_load = 1'b1;
    @(negedge clk);
    seed_load = 1'b0; rule_in = 8'd90; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    push(16'h5A00, 16'h5A00, 8'd0, 0, 0);
    seed_in = 16'h5A00; seed_load = 1'b1;
    @(negedge clk);
    seed_load = 1'b0;
    repeat (4) @(negedge clk);
    chk(row0 == 16'h5A00 && c0 == '0 && !d0, "R10", "aborted run holds seed",
        {row0, c0, d0}, {16'h5A00, GW'(0), 1'b0});
    chk(q0.size() == 0 && q1.size() == 0, "R10", "rows outstanding", 64'(q0.size()), 0);
    // R12: start from the loaded row without a new load
    tag = "R12";
    restart(8'd60);
    settle("R12");
    chk(q0.size() == 0, "R5", "one pulse per generation", 64'(q0.size()), 0);
    finish_up();
  end

endmodule